// File: doc/BRIEF.md
# Daisy-Chainable Serial Channel-Select Controller

This block drives the eight one-hot enables of a switch bank from a slow serial control port. While the select input is high, each rising edge of the serial clock moves one data bit into a small shift register. The bit that falls out of the far end is presented on a serial output, so several units can share one data stream by wiring each unit's serial output to the next unit's serial input.

The register contents are applied only when select falls. At that point every enable drops at once. A configurable gap of system clock cycles follows, and only then is the new enable raised, so two switches are never on together. All three serial-side inputs are asynchronous to the fast system clock. They are brought in through two-flop synchronizers, and serial clock edges are found inside the system clock domain.

The serial output is a data bit paired with an output enable, intended for a tristate pad driver. The enable is high only while the synchronized select is high.

Top module: `chsel_ctrl`

## Requirements
- R1: After synchronous reset, all switch enables are 0 and the serial output enable is 0 (select idles low).
- R2: The shift register advances only on a serial clock rising edge seen while select is high. Serial clock edges while select is low change neither the register, nor the serial output, nor the enables.
- R3: A control word is four bits sent in this order: the enable flag first, then channel bits B2, B1, B0 (most significant first). With the flag at 1, only `sw_en_o[n]` is raised, where n = {B2,B1,B0}.
- R4: With the flag at 0, all eight enables stay 0 whatever B2..B0 hold.
- R5: `sdo_o` is the oldest register bit. A bit shifted in first appears on `sdo_o` after the fourth serial clock rising edge, and not after the third.
- R6: `sdo_en_o` is 0 while the synchronized select is low and 1 while it is high.
- R7: Counted in system clock rising edges after `sel_i` falls, enables keep their old value through edge 2, are all 0 from edge 3, and take the new value at edge 3+OFF_CYCLES.
- R8: An applied channel holds while select is high and bits are being shifted. It changes only at the next select fall, which uses the last four bits shifted in.
- R9: At most one enable is high at any time, and a change from one active channel to another always passes through all-off.
- R10: With two units chained output-to-input under a common select, an 8-bit stream programs the downstream unit with its first four bits and the upstream unit with its last four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Select, asynchronous; high = load, falling edge = apply |
| sclk_i | input | 1 | Serial clock, asynchronous; rising edge shifts |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (oldest register bit) |
| sdo_en_o | output | 1 | Output enable for the serial data pad driver |
| sw_en_o | output | NUM_CH | One-hot switch enables |

## Verification
Every result is counted from system clock edges. A serial clock or select change passes two synchronizer flops and lands in the register on the third rising edge. Enables hold for two edges after select falls, clear on the third, and take the new value on edge 3+OFF_CYCLES. The bench changes inputs only on falling clock edges and samples at the falling edge just after the edge in question, so it checks the old value, the all-off gap and the new value each at its exact cycle. Serial clock phases last four system cycles, which leaves every shift settled before the next bit or check.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
    typedef enum logic [0:0] {
        SEQ_HOLD = 1'b0,
        SEQ_GAP  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/chsel_shifter.sv
module chsel_shifter #(
    parameter int WORD_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_s,
    input  logic                 sclk_s,
    input  logic                 sdi_s,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 sdo_o,
    output logic                 sdo_en_o
);
    typedef struct packed {
        logic                 sclk_p;
        logic [WORD_BITS-1:0] sreg;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d        = shf_q;
        shf_d.sclk_p = sclk_s;
        if (sel_s && sclk_s && !shf_q.sclk_p) begin
            shf_d.sreg = {shf_q.sreg[WORD_BITS-2:0], sdi_s};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) shf_q <= '0;
        else     shf_q <= shf_d;
    end

    assign word_o   = shf_q.sreg;
    assign sdo_o    = shf_q.sreg[WORD_BITS-1];
    assign sdo_en_o = sel_s;
endmodule

// File: rtl/chsel_seq.sv
module chsel_seq
    import chsel_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int SEL_BITS   = 3,
    parameter int OFF_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_s,
    input  logic [SEL_BITS:0]   word_i,
    output logic                sel_fall_o,
    output logic [NUM_CH-1:0]   sw_en_o
);
    localparam int WORD_BITS = SEL_BITS + 1;
    localparam int CNT_W     = $clog2(OFF_CYCLES + 1);

    typedef struct packed {
        seq_state_e           state;
        logic                 sel_p;
        logic [CNT_W-1:0]     cnt;
        logic [WORD_BITS-1:0] pend;
        logic [NUM_CH-1:0]    sw_en;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [NUM_CH-1:0] dec;
    logic              fall;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        assign dec[i] = seq_q.pend[WORD_BITS-1] &&
                        (seq_q.pend[SEL_BITS-1:0] == SEL_BITS'(i));
    end

    assign fall = seq_q.sel_p && !sel_s;

    always_comb begin
        seq_d       = seq_q;
        seq_d.sel_p = sel_s;
        if (fall) begin
            seq_d.sw_en = '0;
            seq_d.pend  = word_i;
            seq_d.cnt   = CNT_W'(OFF_CYCLES - 1);
            seq_d.state = SEQ_GAP;
        end else if (seq_q.state == SEQ_GAP) begin
            if (seq_q.cnt == '0) begin
                seq_d.sw_en = dec;
                seq_d.state = SEQ_HOLD;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign sel_fall_o = fall;
    assign sw_en_o    = seq_q.sw_en;
endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl #(
    parameter int NUM_CH     = 8,
    parameter int OFF_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    output logic [NUM_CH-1:0] sw_en_o
);
    localparam int SEL_BITS  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WORD_BITS = SEL_BITS + 1;

    logic [2:0]           synced;
    logic                 sel_s, sclk_s, sdi_s, sel_fall;
    logic [WORD_BITS-1:0] word;

    chsel_sync #(.WIDTH(3)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({sel_i, sclk_i, sdi_i}),
        .sync_o  (synced)
    );

    assign sel_s  = synced[2];
    assign sclk_s = synced[1];
    assign sdi_s  = synced[0];

    chsel_shifter #(.WORD_BITS(WORD_BITS)) u_shf (
        .clk      (clk),
        .rst      (rst),
        .sel_s    (sel_s),
        .sclk_s   (sclk_s),
        .sdi_s    (sdi_s),
        .word_o   (word),
        .sdo_o    (sdo_o),
        .sdo_en_o (sdo_en_o)
    );

    chsel_seq #(
        .NUM_CH     (NUM_CH),
        .SEL_BITS   (SEL_BITS),
        .OFF_CYCLES (OFF_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sel_s      (sel_s),
        .word_i     (word),
        .sel_fall_o (sel_fall),
        .sw_en_o    (sw_en_o)
    );
endmodule

// File: rtl/chsel_ctrl_chk.sv
module chsel_ctrl_chk #(
    parameter int NUM_CH    = 8,
    parameter int WORD_BITS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sel_s,
    input logic                 sel_fall,
    input logic [WORD_BITS-1:0] word,
    input logic [NUM_CH-1:0]    sw_en
);
    // R1
    reset_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> sw_en == '0);

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_s |=> $stable(word));

    // R7
    fall_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sel_fall |=> sw_en == '0);

    // R9
    one_hot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sw_en));

    // R9
    break_first_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_en != '0) |=> (sw_en == $past(sw_en) || sw_en == '0));
endmodule

bind chsel_ctrl chsel_ctrl_chk #(
    .NUM_CH    (NUM_CH),
    .WORD_BITS (WORD_BITS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_s    (sel_s),
    .sel_fall (sel_fall),
    .word     (word),
    .sw_en    (sw_en_o)
);

// File: tb/tb_chsel_ctrl.sv
module tb_chsel_ctrl;
    localparam int OFF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_a = 1'b0, sel_b = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo_a, sdo_en_a, sdo_b, sdo_en_b;
    logic [7:0] sw_a, sw_b;

    int checks = 0, errors = 0, overlap = 0;
    bit done = 1'b0;
    logic [7:0] cur_a = 8'h00;

    always #10 clk = ~clk;

    chsel_ctrl #(.NUM_CH(8), .OFF_CYCLES(OFF)) dut (
        .clk(clk), .rst(rst), .sel_i(sel_a), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo_a), .sdo_en_o(sdo_en_a), .sw_en_o(sw_a));

    chsel_ctrl #(.NUM_CH(8), .OFF_CYCLES(OFF)) dut_b (
        .clk(clk), .rst(rst), .sel_i(sel_b), .sclk_i(sclk), .sdi_i(sdo_a),
        .sdo_o(sdo_b), .sdo_en_o(sdo_en_b), .sw_en_o(sw_b));

    // word in [11:8] (flag, B2, B1, B0), expected enables in [7:0]
    localparam logic [11:0] VEC [6] = '{
        12'h8_01, 12'hF_80, 12'h5_00, 12'hD_20, 12'hA_04, 12'hE_40
    };

    always @(negedge clk)
        if (!rst && ($countones(sw_a) + $countones(sw_b)) > 1) overlap++;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk) sdi = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send(input logic [7:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic open_sel(input bit both);
        @(negedge clk);
        sel_a = 1'b1;
        sel_b = both;
        repeat (4) @(negedge clk);
    endtask

    task automatic close_sel(input string req, input logic [7:0] exp_a,
                             input bit chk_b, input logic [7:0] exp_b);
        @(negedge clk);
        sel_a = 1'b0;
        sel_b = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) check("R7 old value through edge 2", sw_a, cur_a);
        @(posedge clk);
        @(negedge clk) check("R7 all off at edge 3", sw_a, 8'h00);
        if (chk_b) check("R7 unit b off at edge 3", sw_b, 8'h00);
        repeat (OFF - 1) @(posedge clk);
        @(negedge clk) check("R7 still off before edge 3+OFF", sw_a, 8'h00);
        @(posedge clk);
        @(negedge clk) check(req, sw_a, exp_a);
        if (chk_b) check({req, " unit b"}, sw_b, exp_b);
        cur_a = exp_a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 enables after reset", sw_a, 8'h00);
        check("R1 R6 sdo enable after reset", {7'b0, sdo_en_a}, 8'h00);

        open_sel(1'b0);
        check("R6 sdo enable while select high", {7'b0, sdo_en_a}, 8'h01);
        send(8'b0000_0101, 3);
        check("R5 first bit not out after 3 edges", {7'b0, sdo_a}, 8'h00);
        send(8'b0000_0001, 1);
        check("R5 first bit out after 4 edges", {7'b0, sdo_a}, 8'h01);
        close_sel("R3 channel 3", 8'h08, 1'b0, 8'h00);
        check("R6 sdo enable while select low", {7'b0, sdo_en_a}, 8'h00);

        for (int v = 0; v < 6; v++) begin
            open_sel(1'b0);
            send({4'b0, VEC[v][11:8]}, 4);
            close_sel(VEC[v][11] ? "R3 vector channel" : "R4 flag low all off",
                      VEC[v][7:0], 1'b0, 8'h00);
        end

        // R2: serial clocks with select low are ignored
        send(8'b0000_0000, 4);
        check("R2 enables unchanged", sw_a, 8'h40);
        check("R2 sdo unchanged", {7'b0, sdo_a}, 8'h01);
        open_sel(1'b0);
        close_sel("R2 register kept old word", 8'h40, 1'b0, 8'h00);

        // R8: channel holds while shifting; last four bits win
        open_sel(1'b0);
        send(8'b0010_1001, 6);
        check("R8 hold while shifting", sw_a, 8'h40);
        close_sel("R8 last four bits applied", 8'h02, 1'b0, 8'h00);

        // R10: two units chained under one select
        open_sel(1'b1);
        send(8'b1011_0000, 8);
        close_sel("R10 upstream off", 8'h00, 1'b1, 8'h08);
        open_sel(1'b1);
        send(8'b0000_1110, 8);
        close_sel("R10 upstream channel 6", 8'h40, 1'b1, 8'h00);

        check("R9 no overlap across units", overlap[7:0], 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule